// File: doc/BRIEF.md
# SCSI Controller Host Register File and Command Decoder

This block is the part of a small SCSI bus controller that the host processor talks to. It presents sixteen byte-wide registers on a simple synchronous bus, accepts command bytes, and keeps the status, interrupt-cause and sequence-step registers. It also drives a level-sensitive interrupt line. Several offsets map to one register on reads and to a different one on writes. A read of the interrupt-cause register is destructive: it clears other status fields and drops the interrupt line.

Some commands need real bus activity: the three select forms, transfer information, and initiator command complete. The block only decodes these. For each one it emits a one-cycle request pulse to an external sequencer, along with the DMA-mode bit of the command. Bus phases, the DMA engine and the attached targets live outside this block.

Top module: `scsi_host_regfile`

## Requirements
- R1: After the reset pin is released, offset 8 (configuration 1) reads 0x07, offset 0xE reads 0x04 (variant ID), every other offset reads 0x00, the interrupt line is low, no request pulse is active and the illegal-command flag is low.
- R2: The register index is bus_addr shifted right by ADDR_SHIFT, so the low address bits are ignored. Writes to offsets 4, 5, 6, 7, 9 and 0xA leave every read value unchanged. The low three bits of the last write to offset 4 appear on target_id_o.
- R3: A byte written to offset 8 or to any offset from 0xB to 0xF reads back at that offset, including overwriting the 0x04 at 0xE.
- R4: irq_o always equals bit 7 of the status register read at offset 4.
- R5: A read of offset 5 returns the interrupt-cause value held before the read. In the next cycle, the interrupt-cause register is 0, status bits 7 and 4 are clear, the sequence step (offset 6) reads 4 and irq_o is low. Status bit 4 is the terminal-count flag.
- R6: Command opcode 0x03 (bus reset) sets interrupt cause to 0x80. It raises the interrupt only when bit 6 of configuration 1 is 0.
- R7: Opcode 0x01 (flush) sets interrupt cause to 0x08 and the sequence step to 0. It does not raise the interrupt.
- R8: Opcode 0x12 (message accepted) sets interrupt cause to 0x20 and the sequence step to 0, and raises the interrupt.
- R9: Opcode 0x18 (pad) sets status bits 6:0 to 0x10 and keeps bit 7. It also sets interrupt cause to 0x08 and the sequence step to 0. Opcode 0x44 (enable reselection) sets interrupt cause to 0 and leaves the interrupt line as it was.
- R10: Opcode 0x02 (chip reset) returns every register and target_id_o to the R1 values and lowers irq_o. The illegal-command flag is kept.
- R11: Commands are bytes written to offset 3. Bit 7 is DMA mode and bits 6:0 are the opcode. The request pulse is high in exactly the cycle after the command write: opcode 0x10 drives seq_req_o bit 0, 0x11 bit 1, 0x41 bit 2, 0x42 bit 3 and 0x43 bit 4. seq_req_dma_o copies bit 7 during the pulse. These commands change no register.
- R12: Any opcode outside the set above changes no register and sets bad_cmd_o, which stays set until the reset pin. Opcodes 0x00 and 0x1A change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_SHIFT+4 | Byte address; register index in the top four bits |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Level interrupt |
| seq_req_o | output | 5 | One-hot request pulses to the bus sequencer |
| seq_req_dma_o | output | 1 | DMA-mode bit accompanying a request pulse |
| target_id_o | output | 3 | Target bus ID from the last write to offset 4 |
| bad_cmd_o | output | 1 | Sticky illegal-opcode flag |

## Verification
The hardest state to reach is a pending interrupt together with a set terminal-count bit. Both must then be cleared by one destructive read. The bench raises the line with message accepted and then issues pad, which sets terminal count under the held interrupt flag. It then reads offset 5 and checks the returned cause, the cleared status and the new sequence step. The bus-reset path is run twice, once with configuration bit 6 clear and once with it set. A chip-reset command is issued after the illegal flag has been set, which shows that it survives while everything else returns to reset values.

// File: rtl/scsi_hrf_pkg.sv
`timescale 1ns/1ps
package scsi_hrf_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned NREQ  = 5;
  localparam int unsigned NCFG  = 6;

  localparam logic [IDX_W-1:0] IDX_CMD    = 4'h3;
  localparam logic [IDX_W-1:0] IDX_STATUS = 4'h4;
  localparam logic [IDX_W-1:0] IDX_INTR   = 4'h5;
  localparam logic [IDX_W-1:0] IDX_STEP   = 4'h6;

  localparam logic [6:0] OP_NOP     = 7'h00;
  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_CHIPRST = 7'h02;
  localparam logic [6:0] OP_BUSRST  = 7'h03;
  localparam logic [6:0] OP_XFER    = 7'h10;
  localparam logic [6:0] OP_CMDCPL  = 7'h11;
  localparam logic [6:0] OP_MSGOK   = 7'h12;
  localparam logic [6:0] OP_PAD     = 7'h18;
  localparam logic [6:0] OP_ATN     = 7'h1A;
  localparam logic [6:0] OP_SEL     = 7'h41;
  localparam logic [6:0] OP_SELA    = 7'h42;
  localparam logic [6:0] OP_SELAS   = 7'h43;
  localparam logic [6:0] OP_RESEL   = 7'h44;

  localparam logic [REG_W-1:0] CAUSE_FUNC  = 8'h08;
  localparam logic [REG_W-1:0] CAUSE_DISC  = 8'h20;
  localparam logic [REG_W-1:0] CAUSE_BRST  = 8'h80;
  localparam logic [REG_W-1:0] STEP_DONE   = 8'h04;
  localparam int unsigned      ST_IRQ_BIT  = 7;
  localparam int unsigned      ST_TC_BIT   = 4;
  localparam int unsigned      CFG_QUIET_BIT = 6;

  typedef struct packed {
    logic            flush;
    logic            chip_rst;
    logic            bus_rst;
    logic            msg_ok;
    logic            pad;
    logic            resel;
    logic            illegal;
    logic [NREQ-1:0] req;
    logic            dma;
  } cmd_dec_t;

  function automatic logic [IDX_W-1:0] cfg_index(int unsigned k);
    case (k)
      0:       return 4'h8;
      1:       return 4'hB;
      2:       return 4'hC;
      3:       return 4'hD;
      4:       return 4'hE;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] cfg_reset(logic [IDX_W-1:0] idx);
    case (idx)
      4'h8:    return 8'h07;
      4'hE:    return 8'h04;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/scsi_hrf_cmd_decode.sv
`timescale 1ns/1ps
module scsi_hrf_cmd_decode
  import scsi_hrf_pkg::*;
(
  input  logic [REG_W-1:0] cmd_i,
  output cmd_dec_t         dec_o
);
  logic [6:0] op;
  assign op = cmd_i[6:0];

  always_comb begin
    dec_o     = '0;
    dec_o.dma = cmd_i[7];
    case (op)
      OP_NOP, OP_ATN: ;
      OP_FLUSH:   dec_o.flush    = 1'b1;
      OP_CHIPRST: dec_o.chip_rst = 1'b1;
      OP_BUSRST:  dec_o.bus_rst  = 1'b1;
      OP_MSGOK:   dec_o.msg_ok   = 1'b1;
      OP_PAD:     dec_o.pad      = 1'b1;
      OP_RESEL:   dec_o.resel    = 1'b1;
      OP_XFER:    dec_o.req[0]   = 1'b1;
      OP_CMDCPL:  dec_o.req[1]   = 1'b1;
      OP_SEL:     dec_o.req[2]   = 1'b1;
      OP_SELA:    dec_o.req[3]   = 1'b1;
      OP_SELAS:   dec_o.req[4]   = 1'b1;
      default:    dec_o.illegal  = 1'b1;
    endcase
  end
endmodule

// File: rtl/scsi_hrf_cfg_bank.sv
`timescale 1ns/1ps
module scsi_hrf_cfg_bank
  import scsi_hrf_pkg::*;
#(
  parameter int unsigned N = NCFG
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    soft_rst_i,
  input  logic                    wr_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [REG_W-1:0]        wdata_i,
  output logic [N-1:0][REG_W-1:0] cfg_o
);
  for (genvar k = 0; k < N; k++) begin : g_cfg
    localparam logic [IDX_W-1:0] MY_IDX = cfg_index(k);
    localparam logic [REG_W-1:0] MY_RST = cfg_reset(MY_IDX);
    logic [REG_W-1:0] byte_q, byte_d;
    logic             byte_en;

    always_comb begin
      byte_en = soft_rst_i | (wr_i & (idx_i == MY_IDX));
      byte_d  = soft_rst_i ? MY_RST : wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= MY_RST;
      else if (byte_en) byte_q <= byte_d;
    end

    assign cfg_o[k] = byte_q;
  end
endmodule

// File: rtl/scsi_hrf_req_pulse.sv
`timescale 1ns/1ps
module scsi_hrf_req_pulse
  import scsi_hrf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire_i,
  input  logic [NREQ-1:0] req_i,
  input  logic            dma_i,
  output logic [NREQ-1:0] req_o,
  output logic            dma_o
);
  logic [NREQ-1:0] req_d, req_q;
  logic            dma_d, dma_q;

  always_comb begin
    req_d = fire_i ? req_i : '0;
    dma_d = fire_i & dma_i & (|req_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      dma_q <= 1'b0;
    end else begin
      req_q <= req_d;
      dma_q <= dma_d;
    end
  end

  assign req_o = req_q;
  assign dma_o = dma_q;
endmodule

// File: rtl/scsi_host_regfile.sv
`timescale 1ns/1ps
module scsi_host_regfile
  import scsi_hrf_pkg::*;
#(
  parameter int unsigned ADDR_SHIFT = 2
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_SHIFT+3:0]   bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  output logic                    irq_o,
  output logic [4:0]              seq_req_o,
  output logic                    seq_req_dma_o,
  output logic [2:0]              target_id_o,
  output logic                    bad_cmd_o
);
  localparam int unsigned CFG1_SLOT = 0;

  logic [IDX_W-1:0]           idx;
  cmd_dec_t                   dec;
  logic                       wr_cmd, rd_intr, soft_rst, wr_busid;
  logic [NCFG-1:0][REG_W-1:0] cfg_q;
  logic [REG_W-1:0]           status_q, status_d;
  logic [REG_W-1:0]           intr_q, intr_d;
  logic [REG_W-1:0]           step_q, step_d;
  logic [2:0]                 tgt_q, tgt_d;
  logic                       bad_q, bad_d;

  assign idx = bus_addr[ADDR_SHIFT +: IDX_W];

  if (ADDR_SHIFT > 0) begin : g_lo
    logic unused_addr_lo;
    assign unused_addr_lo = ^bus_addr[ADDR_SHIFT-1:0];
  end

  scsi_hrf_cmd_decode u_dec (
    .cmd_i (bus_wdata),
    .dec_o (dec)
  );

  always_comb begin
    wr_cmd   = bus_wr & (idx == IDX_CMD);
    wr_busid = bus_wr & (idx == IDX_STATUS);
    rd_intr  = bus_rd & ~bus_wr & (idx == IDX_INTR);
    soft_rst = wr_cmd & dec.chip_rst;
  end

  scsi_hrf_cfg_bank #(.N(NCFG)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_i (soft_rst),
    .wr_i       (bus_wr),
    .idx_i      (idx),
    .wdata_i    (bus_wdata),
    .cfg_o      (cfg_q)
  );

  scsi_hrf_req_pulse u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (wr_cmd),
    .req_i  (dec.req),
    .dma_i  (dec.dma),
    .req_o  (seq_req_o),
    .dma_o  (seq_req_dma_o)
  );

  always_comb begin
    status_d = status_q;
    intr_d   = intr_q;
    step_d   = step_q;
    tgt_d    = tgt_q;
    bad_d    = bad_q;
    if (soft_rst) begin
      status_d = '0;
      intr_d   = '0;
      step_d   = '0;
      tgt_d    = '0;
    end else if (wr_cmd) begin
      if (dec.illegal) bad_d = 1'b1;
      if (dec.flush) begin
        intr_d = CAUSE_FUNC;
        step_d = '0;
      end
      if (dec.bus_rst) begin
        intr_d = CAUSE_BRST;
        if (!cfg_q[CFG1_SLOT][CFG_QUIET_BIT]) status_d[ST_IRQ_BIT] = 1'b1;
      end
      if (dec.msg_ok) begin
        intr_d                = CAUSE_DISC;
        step_d                = '0;
        status_d[ST_IRQ_BIT]  = 1'b1;
      end
      if (dec.pad) begin
        status_d = {status_q[ST_IRQ_BIT], 7'h10};
        intr_d   = CAUSE_FUNC;
        step_d   = '0;
      end
      if (dec.resel) intr_d = '0;
    end else if (wr_busid) begin
      tgt_d = bus_wdata[2:0];
    end else if (rd_intr) begin
      intr_d               = '0;
      status_d[ST_IRQ_BIT] = 1'b0;
      status_d[ST_TC_BIT]  = 1'b0;
      step_d               = STEP_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      intr_q   <= '0;
      step_q   <= '0;
      tgt_q    <= '0;
      bad_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      intr_q   <= intr_d;
      step_q   <= step_d;
      tgt_q    <= tgt_d;
      bad_q    <= bad_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (idx)
      IDX_STATUS: bus_rdata = status_q;
      IDX_INTR:   bus_rdata = intr_q;
      IDX_STEP:   bus_rdata = step_q;
      default:    ;
    endcase
    for (int unsigned k = 0; k < NCFG; k++) begin
      if (idx == cfg_index(k)) bus_rdata = cfg_q[k];
    end
  end

  assign irq_o       = status_q[ST_IRQ_BIT];
  assign target_id_o = tgt_q;
  assign bad_cmd_o   = bad_q;
endmodule

// File: rtl/scsi_host_regfile_chk.sv
`timescale 1ns/1ps
module scsi_host_regfile_chk
  import scsi_hrf_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      reg_idx,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [6:0]      cmd_op,
  input logic            rdata_msb,
  input logic            irq_o,
  input logic [NREQ-1:0] seq_req_o,
  input logic            bad_cmd_o
);
  assert_irq_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && reg_idx == 4'h4) |-> (rdata_msb == irq_o));

  assert_intr_read_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && reg_idx == 4'h5) |=> !irq_o);

  assert_flush_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && reg_idx == 4'h3 && cmd_op == 7'h01 && !irq_o) |=> !irq_o);

  assert_msg_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && reg_idx == 4'h3 && cmd_op == 7'h12) |=> irq_o);

  assert_req_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seq_req_o));

  assert_req_after_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|seq_req_o) |-> ($past(bus_wr) && $past(reg_idx) == 4'h3));

  assert_bad_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(bad_cmd_o));
endmodule

bind scsi_host_regfile scsi_host_regfile_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_idx   (bus_addr[ADDR_SHIFT +: 4]),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .cmd_op    (bus_wdata[6:0]),
  .rdata_msb (bus_rdata[7]),
  .irq_o     (irq_o),
  .seq_req_o (seq_req_o),
  .bad_cmd_o (bad_cmd_o)
);

// File: tb/scsi_host_regfile_tb_top.sv
`timescale 1ns/1ps
module scsi_host_regfile_tb_top;
  localparam int unsigned SH = 2;
  localparam int unsigned AW = SH + 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          wr, rd;
  logic [7:0]    wdata;
  logic [7:0]    rdata;
  logic          irq, dma, bad;
  logic [4:0]    req;
  logic [2:0]    tgt;

  always #4 clk = ~clk;

  scsi_host_regfile #(.ADDR_SHIFT(SH)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .seq_req_o(req),
    .seq_req_dma_o(dma), .target_id_o(tgt), .bad_cmd_o(bad)
  );

  int   checks = 0;
  int   errors = 0;
  bit   finished = 1'b0;

  logic [7:0] m_reg [16];
  logic [2:0] m_tgt;
  bit         m_bad;
  logic [4:0] m_req;
  bit         m_dma;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset_regs();
    for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    m_reg[8]  = 8'h07;
    m_reg[14] = 8'h04;
    m_tgt     = 3'd0;
  endtask

  task automatic model_step(bit w, bit r, int idx, logic [7:0] d);
    m_req = '0;
    m_dma = 1'b0;
    if (w) begin
      if (idx == 3) begin
        case (int'(d[6:0]))
          'h00, 'h1A: ;
          'h01: begin m_reg[5] = 8'h08; m_reg[6] = 8'h00; end
          'h02: model_reset_regs();
          'h03: begin m_reg[5] = 8'h80; if (!m_reg[8][6]) m_reg[4][7] = 1'b1; end
          'h10: begin m_req = 5'd1;  m_dma = d[7]; end
          'h11: begin m_req = 5'd2;  m_dma = d[7]; end
          'h41: begin m_req = 5'd4;  m_dma = d[7]; end
          'h42: begin m_req = 5'd8;  m_dma = d[7]; end
          'h43: begin m_req = 5'd16; m_dma = d[7]; end
          'h12: begin m_reg[5] = 8'h20; m_reg[6] = 8'h00; m_reg[4][7] = 1'b1; end
          'h18: begin m_reg[4] = (m_reg[4] & 8'h80) | 8'h10; m_reg[5] = 8'h08; m_reg[6] = 8'h00; end
          'h44: m_reg[5] = 8'h00;
          default: m_bad = 1'b1;
        endcase
      end else if (idx == 4) begin
        m_tgt = d[2:0];
      end else if (idx == 8 || idx >= 11) begin
        m_reg[idx] = d;
      end
    end else if (r && idx == 5) begin
      m_reg[5] = 8'h00;
      m_reg[4] = m_reg[4] & 8'h6F;
      m_reg[6] = 8'h04;
    end
  endtask

  task automatic cyc(bit w, bit r, int idx, logic [7:0] d, string tag, int low = 0);
    wr    = w;
    rd    = r;
    addr  = (AW'(idx) << SH) | AW'(low);
    wdata = d;
    #1;
    if (r) check(tag, $sformatf("rdata@%0h", idx), int'(rdata), int'(m_reg[idx]));
    @(posedge clk);
    model_step(w, r, idx, d);
    @(negedge clk);
    wr = 1'b0;
    rd = 1'b0;
    check("R4",  "irq",       int'(irq), int'(m_reg[4][7]));
    check("R11", "req",       int'(req), int'(m_req));
    check("R11", "req_dma",   int'(dma), int'(m_dma));
    check("R12", "bad_cmd",   int'(bad), int'(m_bad));
    check("R2",  "target_id", int'(tgt), int'(m_tgt));
  endtask

  task automatic wreg(int idx, logic [7:0] d, string tag, int low = 0);
    cyc(1'b1, 1'b0, idx, d, tag, low);
  endtask

  task automatic rreg(int idx, string tag, int low = 0);
    cyc(1'b0, 1'b1, idx, 8'h00, tag, low);
  endtask

  task automatic idle(string tag);
    cyc(1'b0, 1'b0, 0, 8'h00, tag);
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < 16; i++) if (i != 5) rreg(i, tag);
    rreg(5, tag);
  endtask

  initial begin
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    model_reset_regs();
    m_bad = 1'b0; m_req = '0; m_dma = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    idle("R1");
    read_all("R1");

    // R3 readable configuration bytes
    wreg(8, 8'h05, "R3");
    wreg(11, 8'hA5, "R3");
    wreg(12, 8'h3C, "R3");
    wreg(13, 8'h81, "R3");
    wreg(14, 8'hE7, "R3");
    wreg(15, 8'h5A, "R3");
    for (int i = 11; i < 16; i++) rreg(i, "R3");
    rreg(8, "R3");

    // R2 write-only offsets, target id and ignored low address bits
    wreg(4, 8'h5D, "R2");
    wreg(5, 8'hFF, "R2");
    wreg(6, 8'hFF, "R2");
    wreg(7, 8'hFF, "R2");
    wreg(9, 8'hFF, "R2");
    wreg(10, 8'hFF, "R2");
    read_all("R2");
    wreg(11, 8'h69, "R2", 3);
    rreg(11, "R2", 1);
    wreg(4, 8'hF2, "R2", 2);

    // R11 request pulses, with and without DMA bit
    wreg(3, 8'h10, "R11");
    wreg(3, 8'h91, "R11");
    wreg(3, 8'h41, "R11");
    wreg(3, 8'hC2, "R11");
    idle("R11");
    wreg(3, 8'hC3, "R11");
    rreg(4, "R11");
    rreg(6, "R11");

    // R7 flush does not raise
    wreg(3, 8'h01, "R7");
    rreg(6, "R7");
    rreg(5, "R7");
    rreg(6, "R7");

    // R8 message accepted, R9 pad under a pending interrupt, R5 destructive read
    wreg(3, 8'h12, "R8");
    rreg(4, "R8");
    rreg(6, "R8");
    wreg(3, 8'h18, "R9");
    rreg(4, "R9");
    rreg(6, "R9");
    rreg(5, "R5");
    rreg(4, "R5");
    rreg(6, "R5");
    rreg(5, "R5");

    // R6 bus reset with configuration bit 6 clear then set
    wreg(8, 8'h07, "R6");
    wreg(3, 8'h03, "R6");
    rreg(5, "R6");
    wreg(8, 8'h47, "R6");
    wreg(3, 8'h83, "R6");
    rreg(4, "R6");
    rreg(5, "R6");

    // R9 enable reselection clears cause only
    wreg(3, 8'h12, "R9");
    wreg(3, 8'h44, "R9");
    rreg(4, "R9");
    rreg(5, "R9");

    // R12 illegal and no-effect opcodes
    wreg(3, 8'h12, "R12");
    wreg(3, 8'h7F, "R12");
    wreg(3, 8'h00, "R12");
    wreg(3, 8'h1A, "R12");
    wreg(3, 8'h05, "R12");
    rreg(4, "R12");
    rreg(6, "R12");
    rreg(5, "R12");

    // R10 chip reset command
    wreg(3, 8'h12, "R10");
    wreg(4, 8'h06, "R10");
    wreg(13, 8'h99, "R10");
    wreg(3, 8'h02, "R10");
    read_all("R10");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule